// File: doc/BRIEF.md
# Sticky Channel Health Status Monitor

This block gathers three health indications for each of twelve measurement channels: input signal present, excitation reference present, and built-in accuracy test passing. It turns them into three host-readable status words. A status bit reads 1 when its channel is healthy. It reads 0 when that channel has a failure or is not in use. A failure latches: it stays visible until the host reads that word, even if the condition has already cleared. Any state change that arrives while a failure is still unread is kept in a background copy, and the visible word takes that copy when the host reads it.

Signal and reference losses pass through a persistence filter. Short dropouts are therefore never reported. Both monitors freeze while the channels are switched to an off-line test. Four interrupt causes (signal loss, reference loss, angle-change alert, test accuracy error) can be enabled one at a time. An enabled cause latches into an interrupt status word that clears when it is read, and one request line is the OR of the enabled latched causes.

Top module: `chan_health_mon`

## Requirements
- R1: Bit i of each status word belongs to channel i and reads 1 for healthy and 0 for loss or failure. The read addresses are: 0 signal word, 1 reference word, 2 test word, 3 interrupt enable (bits 3:0), 4 interrupt status (bits 3:0). Only address 3 is writable, and a write to any other address changes nothing.
- R2: A channel whose bit is 0 in the active mask reads 0 in all three status words in the same cycle, and it never latches a failure.
- R3: A failure on an active channel clears its status bit on the next edge. The bit stays 0, even after the input recovers, until the host reads that word. The read releases the latch on the read edge.
- R4: While a failure is latched, later input values are tracked in a background copy. On a read, the word takes the background value ANDed with the input present at the read edge. A failure arriving in the read cycle therefore wins and stays latched.
- R5: A signal or reference loss must be present for QUAL_CYC consecutive edges before it counts. Its status bit falls one edge later (QUAL_CYC+1 edges after the loss appears). A shorter dropout has no effect.
- R6: While the off-line test input is high, the signal and reference monitors hold their last filtered values and ignore their raw inputs.
- R7: The interrupt cause bits are bit 0 signal loss, bit 1 reference loss, bit 2 angle-change alert, and bit 3 test accuracy error. A cause fires when a status bit of an active channel falls from 1 to 0, or when the alert input is high. It latches into interrupt status only if its enable bit is 1.
- R8: Reading address 4 clears interrupt status on the read edge. A cause firing in that same cycle stays latched.
- R9: The request output is the OR of latched and enabled causes. It rises on the edge that latches a cause and falls on the read edge that clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_ok_i | input | NCH | Raw signal-present flag per channel |
| ref_ok_i | input | NCH | Raw reference-present flag per channel |
| tst_ok_i | input | NCH | Built-in test pass flag per channel |
| active_i | input | NCH | Active-channel mask |
| offline_test_i | input | 1 | High while an off-line test is running |
| angle_alert_i | input | 1 | Angle-change alert event |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | 4 | Write data for the enable register |
| rdata_o | output | DW | Read data for addr_i |
| sig_stat_o | output | NCH | Signal status word |
| ref_stat_o | output | NCH | Reference status word |
| tst_stat_o | output | NCH | Test status word |
| int_stat_o | output | 4 | Interrupt status word |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has its own delay. Masking and read data are combinational, so they are checked a moment after the input changes. The test word, read releases and interrupt status clearing take effect one edge after the stimulus. Signal and reference losses appear QUAL_CYC+1 edges after the loss starts, and the request line moves on the same edge as the status bit that causes it. All inputs are driven on the falling edge and all outputs are sampled on a later falling edge, after exactly the number of rising edges its path needs. For the filter, the bench also checks one edge early to show the bit has not yet moved.

// File: rtl/chan_health_mon.sv
module chan_health_mon #(
  parameter int NCH      = 12,
  parameter int QUAL_CYC = 4,
  parameter int DW       = 16,
  parameter int AW       = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sig_ok_i,
  input  logic [NCH-1:0] ref_ok_i,
  input  logic [NCH-1:0] tst_ok_i,
  input  logic [NCH-1:0] active_i,
  input  logic           offline_test_i,
  input  logic           angle_alert_i,
  input  logic           rd_en_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [3:0]     wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] sig_stat_o,
  output logic [NCH-1:0] ref_stat_o,
  output logic [NCH-1:0] tst_stat_o,
  output logic [3:0]     int_stat_o,
  output logic           irq_o
);

  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QLAST = CW'(QUAL_CYC - 1);
  localparam logic [AW-1:0] A_IEN = AW'(3);
  localparam logic [AW-1:0] A_IST = AW'(4);

  logic [NCH-1:0] sig_q, ref_q;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_qual
      logic [CW-1:0] s_cnt, r_cnt;
      logic          s_h, r_h;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_cnt <= '0;
          s_h   <= 1'b1;
        end else if (offline_test_i) begin
          s_cnt <= '0;
        end else if (sig_ok_i[g]) begin
          s_cnt <= '0;
          s_h   <= 1'b1;
        end else if (s_cnt == QLAST) begin
          s_h   <= 1'b0;
        end else begin
          s_cnt <= s_cnt + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_cnt <= '0;
          r_h   <= 1'b1;
        end else if (offline_test_i) begin
          r_cnt <= '0;
        end else if (ref_ok_i[g]) begin
          r_cnt <= '0;
          r_h   <= 1'b1;
        end else if (r_cnt == QLAST) begin
          r_h   <= 1'b0;
        end else begin
          r_cnt <= r_cnt + 1'b1;
        end
      end

      assign sig_q[g] = s_h;
      assign ref_q[g] = r_h;
    end
  endgenerate

  logic [2:0][NCH-1:0] live_w, vis_w;
  logic [2:0]          fall;

  assign live_w[0] = sig_q    & active_i;
  assign live_w[1] = ref_q    & active_i;
  assign live_w[2] = tst_ok_i & active_i;

  genvar w;
  generate
    for (w = 0; w < 3; w++) begin : g_word
      logic [NCH-1:0] vis, bg, lck, nxt;
      logic           rd_hit;

      assign rd_hit = rd_en_i && (addr_i == AW'(w));
      assign nxt    = rd_hit ? (bg & live_w[w]) : (live_w[w] & ~lck);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vis <= '1;
          bg  <= '1;
          lck <= '0;
        end else begin
          vis <= nxt;
          bg  <= live_w[w];
          lck <= active_i & ~nxt;
        end
      end

      assign fall[w]  = |(vis & ~nxt & active_i);
      assign vis_w[w] = vis;
    end
  endgenerate

  assign sig_stat_o = vis_w[0] & active_i;
  assign ref_stat_o = vis_w[1] & active_i;
  assign tst_stat_o = vis_w[2] & active_i;

  logic [3:0] ien, ist;
  logic [3:0] cause;
  logic       rd_ist;

  assign cause  = {fall[2], angle_alert_i, fall[1], fall[0]};
  assign rd_ist = rd_en_i && (addr_i == A_IST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      ist <= '0;
    end else begin
      if (wr_en_i && addr_i == A_IEN) ien <= wdata_i;
      ist <= (rd_ist ? 4'b0 : ist) | (cause & ien);
    end
  end

  assign int_stat_o = ist;
  assign irq_o      = |(ist & ien);

  always_comb begin
    case (addr_i)
      AW'(0):  rdata_o = DW'(sig_stat_o);
      AW'(1):  rdata_o = DW'(ref_stat_o);
      AW'(2):  rdata_o = DW'(tst_stat_o);
      A_IEN:   rdata_o = DW'(ien);
      A_IST:   rdata_o = DW'(ist);
      default: rdata_o = '0;
    endcase
  end

endmodule

module chan_health_mon_chk #(
  parameter int NCH = 12,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] active_i,
  input logic           offline_test_i,
  input logic           angle_alert_i,
  input logic           rd_en_i,
  input logic [AW-1:0]  addr_i,
  input logic [NCH-1:0] sig_stat_o,
  input logic [NCH-1:0] ref_stat_o,
  input logic [NCH-1:0] tst_stat_o,
  input logic [3:0]     int_stat_o,
  input logic           irq_o
);

  assert_inactive_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig_stat_o | ref_stat_o | tst_stat_o) & ~active_i) == '0);

  assert_latch_until_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(rd_en_i) && $past(addr_i) == AW'(0)) |->
      ((~$past(sig_stat_o) & $past(active_i) & $past(active_i, 2) & active_i & sig_stat_o) == '0));

  assert_hold_in_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(offline_test_i) && $past(offline_test_i, 2) &&
     !($past(rd_en_i) && $past(addr_i) == AW'(1)) &&
     $stable(active_i) && $past(active_i) == $past(active_i, 2)) |-> $stable(ref_stat_o));

  assert_alert_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat_o[2]) |-> $past(angle_alert_i));

  assert_irq_needs_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (int_stat_o != 4'b0));

endmodule

bind chan_health_mon chan_health_mon_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active_i(active_i), .offline_test_i(offline_test_i),
  .angle_alert_i(angle_alert_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .sig_stat_o(sig_stat_o), .ref_stat_o(ref_stat_o), .tst_stat_o(tst_stat_o),
  .int_stat_o(int_stat_o), .irq_o(irq_o)
);

// File: tb/chan_health_mon_bench.sv
`timescale 1ns/1ps
module chan_health_mon_bench;
  localparam int QC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sig_ok = '0, ref_ok = '0, tst_ok = '0, active = '0;
  logic        offline = 1'b0, alert = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  wdata = '0;
  logic [15:0] rdata;
  logic [11:0] sig_stat, ref_stat, tst_stat;
  logic [3:0]  int_stat;
  logic        irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  chan_health_mon #(.NCH(12), .QUAL_CYC(QC), .DW(16), .AW(3)) u_chan_health_mon (
    .clk(clk), .rst_n(rst_n), .sig_ok_i(sig_ok), .ref_ok_i(ref_ok), .tst_ok_i(tst_ok),
    .active_i(active), .offline_test_i(offline), .angle_alert_i(alert),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sig_stat_o(sig_stat), .ref_stat_o(ref_stat), .tst_stat_o(tst_stat),
    .int_stat_o(int_stat), .irq_o(irq));

  // row: {test input, read of address 2, expected test word after the edge}
  localparam logic [24:0] VEC [0:10] = '{
    {12'hFFF, 1'b0, 12'hFFF},   // R1 healthy
    {12'hFFE, 1'b0, 12'hFFE},   // R3 failure latches
    {12'hFFF, 1'b0, 12'hFFE},   // R3 recovery held
    {12'hFFF, 1'b1, 12'hFFF},   // R4 read applies background
    {12'hF7F, 1'b1, 12'hF7F},   // R4 failure in read cycle wins
    {12'hFFF, 1'b0, 12'hF7F},   // R3 held
    {12'hFFF, 1'b0, 12'hF7F},   // R3 held
    {12'hFFF, 1'b1, 12'hFFF},   // R3 read releases
    {12'h0FF, 1'b0, 12'h0FF},   // R1 multi-channel failure
    {12'hFFF, 1'b1, 12'h0FF},   // R4 background still low
    {12'hFFF, 1'b1, 12'hFFF}    // R4 background now high
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [3:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    cyc(1);
    rd_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R2 reset status", {sig_stat, ref_stat, tst_stat}, 36'h0);
    chk("R8 reset int", {int_stat, irq}, 5'h0);

    sig_ok = '1; ref_ok = '1; tst_ok = '1; active = '1;
    cyc(2);
    chk("R1 all healthy", {sig_stat, ref_stat, tst_stat}, 36'hFFF_FFF_FFF);

    for (int i = 0; i < 11; i++) begin
      tst_ok = VEC[i][24:13];
      rd_en = VEC[i][12];
      addr = 3'd2;
      cyc(1);
      rd_en = 1'b0;
      chk($sformatf("R3/R4 table row %0d", i), tst_stat, VEC[i][11:0]);
    end

    addr = 3'd2; #1;
    chk("R1 read map test word", rdata, 16'h0FFF);
    wr_reg(3'd0, 4'h0);
    chk("R1 write to status ignored", sig_stat, 12'hFFF);

    wr_reg(3'd3, 4'b0001);
    addr = 3'd3; #1;
    chk("R1 enable readback", rdata, 16'h0001);

    sig_ok[3] = 1'b0;
    cyc(QC - 1);
    sig_ok[3] = 1'b1;
    cyc(3);
    chk("R5 short dropout ignored", sig_stat, 12'hFFF);

    sig_ok[3] = 1'b0;
    cyc(QC);
    chk("R5 not yet reported", {sig_stat, irq}, {12'hFFF, 1'b0});
    cyc(1);
    chk("R5 loss reported", sig_stat, 12'hFF7);
    chk("R9 irq with status", {int_stat, irq}, {4'b0001, 1'b1});
    sig_ok[3] = 1'b1;
    cyc(2);
    chk("R3 loss held after recovery", sig_stat, 12'hFF7);
    addr = 3'd4; #1;
    chk("R7 int status read", rdata, 16'h0001);
    rd_reg(3'd4);
    chk("R8 cleared on read", int_stat, 4'b0000);
    chk("R9 irq drops after read", irq, 1'b0);
    rd_reg(3'd0);
    chk("R3 released by read", sig_stat, 12'hFFF);

    ref_ok[5] = 1'b0;
    cyc(QC + 2);
    chk("R7 disabled cause status", ref_stat, 12'hFDF);
    chk("R7 disabled cause not latched", {int_stat, irq}, 5'h0);
    ref_ok[5] = 1'b1;
    cyc(2);
    rd_reg(3'd1);
    chk("R3 ref released", ref_stat, 12'hFFF);

    offline = 1'b1;
    cyc(1);
    ref_ok[9] = 1'b0; sig_ok[0] = 1'b0;
    cyc(QC + 3);
    chk("R6 monitors frozen", {sig_stat, ref_stat}, 24'hFFF_FFF);
    ref_ok[9] = 1'b1; sig_ok[0] = 1'b1;
    cyc(2);
    offline = 1'b0;
    cyc(2);
    chk("R6 no loss after test", {sig_stat, ref_stat}, 24'hFFF_FFF);

    wr_reg(3'd3, 4'b0100);
    alert = 1'b1;
    cyc(1);
    alert = 1'b0;
    chk("R7 alert latched", {int_stat, irq}, {4'b0100, 1'b1});
    rd_en = 1'b1; addr = 3'd4; alert = 1'b1;
    cyc(1);
    rd_en = 1'b0; alert = 1'b0;
    chk("R8 new cause wins over read", {int_stat, irq}, {4'b0100, 1'b1});
    rd_reg(3'd4);
    chk("R8 second read clears", {int_stat, irq}, 5'h0);

    active = 12'h0F0; #1;
    chk("R2 mask same cycle", sig_stat, 12'h0F0);
    tst_ok[0] = 1'b0;
    cyc(2);
    chk("R2 inactive reads zero", tst_stat, 12'h0F0);
    tst_ok[0] = 1'b1; active = '1;
    cyc(2);
    chk("R2 inactive never latched", tst_stat, 12'hFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule